// File: doc/BRIEF.md
# Serial Configuration Scan Register

This block is the data register that a boundary-scan test port selects when software programs or inspects the device configuration. It has two parts. The first is a 112-stage serial chain that sits between the test data input and the test data output. The second is a 96-bit volatile configuration register that holds the live settings and drives them out in parallel. The test access controller supplies three strobes: capture, shift and update. Every strobe is sampled on the rising edge of the test clock. A mode select chooses between the programming instruction (write) and the readback instruction (read).

When the write instruction is active, the host shifts in 112 bits. Configuration bit 0 goes first and bit 95 is the 96th bit. The last 16 bits are filler that push the data into place. At update, the low 96 stages of the chain are copied into the configuration register. The top 16 stages are reserved and never reach it. When the read instruction is active, capture loads the chain with the configuration and with zeros in the reserved tail. Configuration bit 0 is then the first bit to appear on the output.

A restore controller can also load the configuration register directly through a parallel port. This load wins over a serial update in the same cycle. Reset clears the configuration register, so every bit reads 0 until a restore or a write puts data in. If capture and shift are both asserted in one cycle, capture takes precedence.

Top module: `cfg_scan_path`

## Requirements
- R1: The serial chain is exactly 112 stages long. A bit driven on `tdi` during shift appears on `tdo` 112 shift cycles later.
- R2: In write mode (`wr_mode`=1), the bit shifted in first is bit 0, so the k-th bit shifted (counting from 0) lands in `cfg_out[k]` after a 112-bit shift and an update.
- R3: The 16 stages nearest `tdi` (the last 16 bits shifted in a write) are reserved. They never change `cfg_out`, and a read-mode capture fills them with 0, so bits 96 to 111 of a read stream are 0.
- R4: In read mode (`wr_mode`=0), capture copies `cfg_out` into the chain. `tdo` then presents `cfg_out[0]` first and `cfg_out[k]` as the k-th bit of the stream.
- R5: While `rst_n` is low, `cfg_out` is 0 and `tdo` is 0. After reset, a read scan returns 112 zeros.
- R6: `cfg_out` changes only on a write-mode update or a parallel load. Shifting, capture, and an update in read mode leave it unchanged.
- R7: When `load_en` is high on a rising edge, `cfg_out` takes `load_data`. This holds even if a write-mode update is asserted in the same cycle.
- R8: `tdi` is sampled on the rising edge of `tck`. `tdo` changes only on the falling edge, so it holds its value across a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| capture_dr | input | 1 | Capture strobe (read mode only) |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe (write mode only) |
| wr_mode | input | 1 | 1 = write instruction, 0 = read instruction |
| load_en | input | 1 | Parallel load from restore controller |
| load_data | input | 96 | Parallel configuration from restore controller |
| cfg_out | output | 96 | Live configuration bits |

## Verification
The embedded properties check several things on every clock edge. The configuration holds its value unless a load or a write-mode update occurs. A parallel load always wins. A read capture mirrors the configuration and zeroes the reserved tail. Each shift moves the chain by one stage and takes in `tdi`. Other behaviour only shows up over whole scans, so the bench scenarios cover it. These are the bit ordering of complete 112-bit writes and reads, the fact that filler bits never leak into the configuration, the full 112-cycle latency from input to output, and the timing of `tdo` on the falling edge.

// File: rtl/cfg_scan_path.sv
module cfg_scan_path #(
  parameter int CFG_W = 96,
  parameter int RSV_W = 16
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tdi,
  output logic             tdo,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             wr_mode,
  input  logic             load_en,
  input  logic [CFG_W-1:0] load_data,
  output logic [CFG_W-1:0] cfg_out
);
  localparam int PATH_W = CFG_W + RSV_W;

  logic [PATH_W-1:0] chain;
  logic [CFG_W-1:0]  cfg_q;
  logic              tdo_q;

  wire rd_cap = capture_dr && !wr_mode;
  wire wr_upd = update_dr && wr_mode;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)
      chain <= '0;
    else if (rd_cap)
      chain <= {{RSV_W{1'b0}}, cfg_q};
    else if (shift_dr)
      chain <= {tdi, chain[PATH_W-1:1]};

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)
      cfg_q <= '0;
    else if (load_en)
      cfg_q <= load_data;
    else if (wr_upd)
      cfg_q <= chain[CFG_W-1:0];

  always_ff @(negedge tck or negedge rst_n)
    if (!rst_n)
      tdo_q <= 1'b0;
    else
      tdo_q <= chain[0];

  assign cfg_out = cfg_q;
  assign tdo     = tdo_q;

  // R6
  cfg_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !load_en && !wr_upd |=> $stable(cfg_out));

  // R7
  load_first_chk: assert property (@(posedge tck) disable iff (!rst_n)
    load_en |=> cfg_out == $past(load_data));

  // R3
  rsv_zero_chk: assert property (@(posedge tck) disable iff (!rst_n)
    rd_cap |=> chain[PATH_W-1:CFG_W] == '0);

  // R4
  capture_mirror_chk: assert property (@(posedge tck) disable iff (!rst_n)
    rd_cap |=> chain[CFG_W-1:0] == $past(cfg_out));

  // R1
  shift_step_chk: assert property (@(posedge tck) disable iff (!rst_n)
    shift_dr && !rd_cap |=> chain[PATH_W-1] == $past(tdi)
                          && chain[PATH_W-2:0] == $past(chain[PATH_W-1:1]));

  // R5
  always @(posedge tck)
    if (!rst_n)
      reset_clear_chk: assert (cfg_out == '0 && tdo == 1'b0);
endmodule

// File: tb/cfg_scan_path_test.sv
`timescale 1ns/1ps
module cfg_scan_path_test;
  localparam int CW = 96;
  localparam int PW = 112;
  localparam int NV = 5;
  localparam logic [PW-1:0] VEC [NV] = '{
    {16'hFFFF, 96'h0},
    {16'h0000, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF},
    {16'hA5C3, 96'h8000_0000_0000_0000_0000_0001},
    {16'h1234, 96'hDEAD_BEEF_0123_4567_89AB_CDEF},
    {16'h5A5A, 96'h5555_AAAA_0F0F_F0F0_3C3C_C3C3}
  };

  logic tck = 0, rst_n = 0, tdi = 0, capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic wr_mode = 0, load_en = 0, tdo;
  logic [CW-1:0] load_data = '0, cfg_out;
  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  cfg_scan_path uut (.tck(tck), .rst_n(rst_n), .tdi(tdi), .tdo(tdo),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .wr_mode(wr_mode), .load_en(load_en), .load_data(load_data), .cfg_out(cfg_out));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic s, input logic u, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo;
    capture_dr = c; shift_dr = s; update_dr = u; tdi = d;
  endtask

  task automatic shift_in(input logic [PW-1:0] v);
    logic o;
    wr_mode = 1;
    for (int i = 0; i < PW; i++) drive(0, 1, 0, v[i], o);
  endtask

  task automatic commit();
    logic o;
    drive(0, 0, 1, 0, o);
    drive(0, 0, 0, 0, o);
  endtask

  task automatic read_scan(input logic [7:0] mark, output logic [PW+7:0] got);
    logic o;
    wr_mode = 0;
    drive(1, 0, 0, 0, o);
    for (int i = 0; i < PW + 8; i++) begin
      drive(0, 1, 0, (i < 8) ? mark[i] : 1'b0, o);
      got[i] = o;
    end
    drive(0, 0, 0, 0, o);
  endtask

  task automatic pload(input logic [CW-1:0] d);
    @(negedge tck); #1; load_en = 1; load_data = d;
    @(negedge tck); #1; load_en = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [PW+7:0] got;
    logic [CW-1:0] prev;
    logic o;
    #7;
    // R5 reset state
    chk(cfg_out == '0, "R5 cfg in reset", cfg_out, 0);
    chk(tdo == 1'b0, "R5 tdo in reset", tdo, 0);
    @(negedge tck); #1; rst_n = 1;
    read_scan(8'h00, got);
    chk(got[PW-1:0] == '0, "R5 read after reset", got, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] mk;
      mk = 8'(v * 37 + 11);
      prev = cfg_out;
      shift_in(VEC[v]);
      chk(cfg_out == prev, "R6 hold during shift", cfg_out, prev);
      commit();
      chk(cfg_out == VEC[v][CW-1:0], "R2 R3 write update", cfg_out, VEC[v][CW-1:0]);
      read_scan(mk, got);
      chk(got[CW-1:0] == VEC[v][CW-1:0], "R4 read order", got[CW-1:0], VEC[v][CW-1:0]);
      chk(got[PW-1:CW] == '0, "R3 reserved tail zero", got[PW-1:CW], 0);
      chk(got[PW+7:PW] == mk, "R1 path length", got[PW+7:PW], mk);
      prev = cfg_out;
      drive(0, 0, 1, 0, o);
      drive(0, 0, 0, 0, o);
      chk(cfg_out == prev, "R6 read-mode update ignored", cfg_out, prev);
    end

    // R7 load alone and load versus update
    pload(96'h0123_4567_89AB_CDEF_FEDC_BA98);
    chk(cfg_out == 96'h0123_4567_89AB_CDEF_FEDC_BA98, "R7 load", cfg_out, 96'h0123_4567_89AB_CDEF_FEDC_BA98);
    shift_in({16'h0, 96'hFFFF_0000_FFFF_0000_FFFF_0000});
    @(negedge tck); #1; load_en = 1; load_data = 96'h1111_2222_3333_4444_5555_6666; update_dr = 1;
    @(negedge tck); #1; load_en = 0; update_dr = 0;
    chk(cfg_out == 96'h1111_2222_3333_4444_5555_6666, "R7 load beats update", cfg_out, 96'h1111_2222_3333_4444_5555_6666);

    // R8 tdo edge
    pload(96'h5);
    wr_mode = 0;
    drive(1, 0, 0, 0, o);
    drive(0, 1, 0, 0, o);
    chk(o == 1'b1, "R8 first bit", o, 1);
    @(posedge tck); #1;
    chk(tdo == 1'b1, "R8 tdo holds over rising edge", tdo, 1);
    @(negedge tck); #1;
    chk(tdo == 1'b0, "R8 tdo moves on falling edge", tdo, 0);
    shift_dr = 0;

    // R8 tdi sampled at rising edge: change tdi right after it
    wr_mode = 1;
    for (int i = 0; i < PW; i++) begin
      @(negedge tck); #1; shift_dr = 1; tdi = (i == 0);
      @(posedge tck); #1; tdi = ~tdi;
    end
    commit();
    chk(cfg_out == 96'h1, "R8 tdi rising sample", cfg_out, 96'h1);

    // R5 reset mid-operation
    @(negedge tck); #1; rst_n = 0;
    #1;
    chk(cfg_out == '0, "R5 async clear", cfg_out, 0);
    @(negedge tck); #1; rst_n = 1;

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule